// File: doc/BRIEF.md
# Processor Bus Glue with Interrupt Priority Encoder

This block is the combinational glue placed between a processor bus (16-bit data, 24-bit byte address) and the memories and interrupt sources around it. It turns the bus's active-low address strobe, its two active-low byte-lane data strobes and its single read/write line into separate active-low read and write strobes. It also produces per-lane chip selects for a ROM pair and a RAM pair, and one chip select for a single I/O window.

Each memory is built from two byte-wide devices, one on the upper data lane and one on the lower. The block asserts a lane's select only when the processor strobes that lane. A byte write therefore touches only the addressed device, and a word access enables both devices. Nothing is decoded while the address strobe is high.

Seven active-low interrupt request lines are prioritised. The index of the highest request that is asserted is presented, inverted, on a 3-bit active-low level bus that the processor samples. The window bases, window sizes, address width and request count are parameters. The windows are checked for alignment and overlap when the design is elaborated.

Top module: `cpu_bus_glue`

## Requirements
- R1: While `as_n` is high, every chip select (`rom_hi_cs_n`, `rom_lo_cs_n`, `ram_hi_cs_n`, `ram_lo_cs_n`, `io_cs_n`) and both `rd_n` and `wr_n` are high, whatever the address, lane strobes and `rw` are.
- R2: With `as_n` low, `rd_n` is low exactly when `rw` is 1 (read), and `wr_n` is low exactly when `rw` is 0 (write). The two are never low together.
- R3: A byte address from 0x000000 to 0x03FFFF (256 KB), with `as_n` low, selects the ROM pair.
- R4: A byte address from 0x100000 to 0x13FFFF, with `as_n` low, selects the RAM pair.
- R5: Within a selected memory, the `_hi_` select is low only if `uds_n` is low, and the `_lo_` select is low only if `lds_n` is low. With both strobes low, both selects are low. With neither strobe low, neither select is low.
- R6: An address outside both memory windows asserts no memory select. The I/O window, 0x200000 to 0x20FFFF by default, asserts `io_cs_n` on `as_n` alone, independent of the lane strobes.
- R7: `ipl_n` is the bitwise inverse of the index of the highest asserted request in `irq_n[7:1]`. With `irq_n[7]` low, `ipl_n` is 3'b000. With only `irq_n[6]` low, `ipl_n` is 3'b001 (bit 0 high, bits 1 and 2 low).
- R8: Asserting any lower-numbered request in addition to a higher one leaves `ipl_n` unchanged.
- R9: With no request asserted, `ipl_n` is 3'b111 (level 0).
- R10: `ipl_n` does not depend on `as_n`, the address, the lane strobes or `rw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 23 | Bus address bits 23..1 (word address) |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper byte-lane data strobe, active low |
| lds_n | input | 1 | Lower byte-lane data strobe, active low |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| irq_n | input | 7 | Interrupt requests 7..1, active low, 7 highest |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rom_hi_cs_n | output | 1 | ROM upper-lane device select, active low |
| rom_lo_cs_n | output | 1 | ROM lower-lane device select, active low |
| ram_hi_cs_n | output | 1 | RAM upper-lane device select, active low |
| ram_lo_cs_n | output | 1 | RAM lower-lane device select, active low |
| io_cs_n | output | 1 | I/O window select, active low |
| ipl_n | output | 3 | Encoded interrupt level, active low |

## Verification
The bench probes the last word of each window and the first word past it. A decoder with an off-by-one limit or a wrong mask would select the neighbouring region there, or fail to select at all. It applies single-lane accesses to both memories, where a design that ignored the data strobes would enable both devices of a pair and corrupt the other byte on a write. It holds the address strobe high on addresses inside the windows, which catches selects or strobes that are not qualified by it. All 128 request patterns are walked, with extra cases of a low-priority request stacked under a higher one: a lowest-wins or OR-of-indices encoder would change the level there, and an encoder missing its inversion would present level 7 when idle.

// File: rtl/glue_pkg.sv
`timescale 1ns/1ps
package glue_pkg;

   // Byte-lane pair of active-low selects for a two-device memory bank.
   typedef struct packed {
      logic hi_n;
      logic lo_n;
   } lane_sel_t;

   // True when the half-open windows [b1, b1+s1) and [b2, b2+s2) share a byte.
   function automatic bit win_overlap(input longint unsigned b1, input longint unsigned s1,
                                      input longint unsigned b2, input longint unsigned s2);
      return (b1 < b2 + s2) && (b2 < b1 + s1);
   endfunction

   // True when size is a power of two and base sits on a multiple of it.
   function automatic bit win_aligned(input longint unsigned b, input longint unsigned s);
      return (s != 0) && ((s & (s - 1)) == 0) && ((b & (s - 1)) == 0);
   endfunction

endpackage

// File: rtl/cpu_bus_window.sv
`timescale 1ns/1ps
module cpu_bus_window #(
   parameter int unsigned       ADDR_W = 24,
   parameter logic [ADDR_W-1:0] BASE   = '0,
   parameter logic [ADDR_W-1:0] SIZE   = ADDR_W'(32'h0001_0000)
) (
   input  logic [ADDR_W-1:1] addr,
   output logic              hit
);
   import glue_pkg::*;

   localparam bit ALIGNED = win_aligned(longint'(BASE), longint'(SIZE));
   localparam logic [ADDR_W:0] LAST = {1'b0, BASE} + {1'b0, SIZE} - 1'b1;

   logic [ADDR_W-1:0] byte_addr;
   assign byte_addr = {addr, 1'b0};

   initial begin
      if (SIZE == '0) $error("cpu_bus_window: window size must be non-zero");
      if (SIZE[0]) $error("cpu_bus_window: window size must be a whole number of words");
      if (LAST[ADDR_W]) $error("cpu_bus_window: window runs past the address space");
   end

   generate
      if (ALIGNED) begin : g_mask
         // Power-of-two, aligned window: compare only the bits above the size.
         localparam logic [ADDR_W-1:0] MASK = ~(SIZE - 1'b1);
         assign hit = ((byte_addr & MASK) == BASE);
      end else begin : g_range
         // Arbitrary window: two magnitude compares.
         assign hit = ({1'b0, byte_addr} >= {1'b0, BASE}) &&
                      ({1'b0, byte_addr} <= LAST);
      end
   endgenerate

endmodule

// File: rtl/cpu_bus_lane.sv
`timescale 1ns/1ps
module cpu_bus_lane (
   input  logic                  region_sel,
   input  logic                  uds_n,
   input  logic                  lds_n,
   output glue_pkg::lane_sel_t   cs
);
   // region_sel already carries the address-strobe qualification.
   assign cs.hi_n = ~(region_sel & ~uds_n);
   assign cs.lo_n = ~(region_sel & ~lds_n);

   always_comb begin
      AST_HI_NEEDS_UDS: assert (cs.hi_n || !uds_n) else $error("upper select without upper strobe"); // R5
      AST_LO_NEEDS_LDS: assert (cs.lo_n || !lds_n) else $error("lower select without lower strobe"); // R5
   end

endmodule

// File: rtl/cpu_irq_encoder.sv
`timescale 1ns/1ps
module cpu_irq_encoder #(
   parameter int unsigned N_IRQ = 7,
   localparam int unsigned LVL_W = $clog2(N_IRQ + 1)
) (
   input  logic [N_IRQ:1]   req_n,
   output logic [LVL_W-1:0] lvl_n
);
   logic [LVL_W-1:0] lvl;

   initial begin
      if (N_IRQ < 1) $error("cpu_irq_encoder: at least one request line is needed");
   end

   // Ascending scan: the last asserted line seen is the highest one.
   always_comb begin
      lvl = '0;
      for (int i = 1; i <= N_IRQ; i++) begin
         if (!req_n[i]) lvl = LVL_W'(i);
      end
   end

   assign lvl_n = ~lvl;

   always_comb begin
      AST_IDLE_LEVEL: assert (!(&req_n) || (&lvl_n)) else $error("level not zero when idle"); // R9
      AST_TOP_LEVEL: assert (req_n[N_IRQ] || (lvl_n == ~LVL_W'(N_IRQ))) else $error("top request not encoded"); // R7
   end

endmodule

// File: rtl/cpu_bus_glue.sv
`timescale 1ns/1ps
module cpu_bus_glue #(
   parameter int unsigned       ADDR_W   = 24,
   parameter int unsigned       N_IRQ    = 7,
   parameter logic [ADDR_W-1:0] ROM_BASE = ADDR_W'(32'h0000_0000),
   parameter logic [ADDR_W-1:0] ROM_SIZE = ADDR_W'(32'h0004_0000),
   parameter logic [ADDR_W-1:0] RAM_BASE = ADDR_W'(32'h0010_0000),
   parameter logic [ADDR_W-1:0] RAM_SIZE = ADDR_W'(32'h0004_0000),
   parameter bit                IO_EN    = 1'b1,
   parameter logic [ADDR_W-1:0] IO_BASE  = ADDR_W'(32'h0020_0000),
   parameter logic [ADDR_W-1:0] IO_SIZE  = ADDR_W'(32'h0001_0000),
   localparam int unsigned      LVL_W    = $clog2(N_IRQ + 1)
) (
   input  logic [ADDR_W-1:1] addr,
   input  logic              as_n,
   input  logic              uds_n,
   input  logic              lds_n,
   input  logic              rw,
   input  logic [N_IRQ:1]    irq_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic              rom_hi_cs_n,
   output logic              rom_lo_cs_n,
   output logic              ram_hi_cs_n,
   output logic              ram_lo_cs_n,
   output logic              io_cs_n,
   output logic [LVL_W-1:0]  ipl_n
);
   import glue_pkg::*;

   initial begin
      if (win_overlap(longint'(ROM_BASE), longint'(ROM_SIZE),
                      longint'(RAM_BASE), longint'(RAM_SIZE)))
         $error("cpu_bus_glue: ROM and RAM windows overlap");
      if (IO_EN && win_overlap(longint'(IO_BASE), longint'(IO_SIZE),
                               longint'(ROM_BASE), longint'(ROM_SIZE)))
         $error("cpu_bus_glue: I/O and ROM windows overlap");
      if (IO_EN && win_overlap(longint'(IO_BASE), longint'(IO_SIZE),
                               longint'(RAM_BASE), longint'(RAM_SIZE)))
         $error("cpu_bus_glue: I/O and RAM windows overlap");
   end

   // ---------------- bus cycle qualification ----------------
   logic cyc;
   assign cyc  = ~as_n;
   assign rd_n = ~(cyc & rw);
   assign wr_n = ~(cyc & ~rw);

   // ---------------- address decode ----------------
   logic rom_hit, ram_hit, io_hit;

   cpu_bus_window #(.ADDR_W(ADDR_W), .BASE(ROM_BASE), .SIZE(ROM_SIZE)) u_rom_win (
      .addr (addr),
      .hit  (rom_hit)
   );

   cpu_bus_window #(.ADDR_W(ADDR_W), .BASE(RAM_BASE), .SIZE(RAM_SIZE)) u_ram_win (
      .addr (addr),
      .hit  (ram_hit)
   );

   generate
      if (IO_EN) begin : g_io
         cpu_bus_window #(.ADDR_W(ADDR_W), .BASE(IO_BASE), .SIZE(IO_SIZE)) u_io_win (
            .addr (addr),
            .hit  (io_hit)
         );
      end else begin : g_no_io
         assign io_hit = 1'b0;
      end
   endgenerate

   // ---------------- byte-lane split ----------------
   lane_sel_t rom_cs, ram_cs;

   cpu_bus_lane u_rom_lane (
      .region_sel (cyc & rom_hit),
      .uds_n      (uds_n),
      .lds_n      (lds_n),
      .cs         (rom_cs)
   );

   cpu_bus_lane u_ram_lane (
      .region_sel (cyc & ram_hit),
      .uds_n      (uds_n),
      .lds_n      (lds_n),
      .cs         (ram_cs)
   );

   assign rom_hi_cs_n = rom_cs.hi_n;
   assign rom_lo_cs_n = rom_cs.lo_n;
   assign ram_hi_cs_n = ram_cs.hi_n;
   assign ram_lo_cs_n = ram_cs.lo_n;
   assign io_cs_n     = ~(cyc & io_hit);

   // ---------------- interrupt prioritisation ----------------
   cpu_irq_encoder #(.N_IRQ(N_IRQ)) u_irq (
      .req_n (irq_n),
      .lvl_n (ipl_n)
   );

   // ---------------- checks ----------------
   logic any_cs;
   assign any_cs = ~(rom_hi_cs_n & rom_lo_cs_n & ram_hi_cs_n & ram_lo_cs_n & io_cs_n);

   always_comb begin
      AST_NO_CS_IDLE: assert (!as_n || (!any_cs && rd_n && wr_n)) else $error("select or strobe without address strobe"); // R1
      AST_STROBE_EXCL: assert (rd_n || wr_n) else $error("read and write strobes both active"); // R2
      AST_ONE_REGION: assert ($onehot0({~(rom_hi_cs_n & rom_lo_cs_n), ~(ram_hi_cs_n & ram_lo_cs_n), ~io_cs_n})) else $error("more than one region selected"); // R6
   end

endmodule

// File: tb/cpu_bus_glue_test.sv
`timescale 1ns/1ps
module cpu_bus_glue_test;

   localparam int unsigned WATCHDOG_NS = 1_000_000;

   logic        clk = 1'b0;
   logic [23:1] addr;
   logic        as_n, uds_n, lds_n, rw;
   logic [7:1]  irq_n;
   logic        rd_n, wr_n, rom_hi_cs_n, rom_lo_cs_n, ram_hi_cs_n, ram_lo_cs_n, io_cs_n;
   logic [2:0]  ipl_n;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   cpu_bus_glue uut (
      .addr(addr), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n), .rw(rw), .irq_n(irq_n),
      .rd_n(rd_n), .wr_n(wr_n), .rom_hi_cs_n(rom_hi_cs_n), .rom_lo_cs_n(rom_lo_cs_n),
      .ram_hi_cs_n(ram_hi_cs_n), .ram_lo_cs_n(ram_lo_cs_n), .io_cs_n(io_cs_n), .ipl_n(ipl_n)
   );

   // exp = {rd_n, wr_n, rom_hi, rom_lo, ram_hi, ram_lo, io}
   typedef struct packed {
      logic [23:0] a;
      logic        as_n;
      logic        uds_n;
      logic        lds_n;
      logic        rw;
      logic [6:0]  exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{24'h000000, 1'b1, 1'b0, 1'b0, 1'b1, 7'b1111111, 8'd1},  // R1 idle strobe on ROM
      '{24'h000000, 1'b0, 1'b0, 1'b0, 1'b1, 7'b0100111, 8'd3},  // R3 ROM word read
      '{24'h03FFFE, 1'b0, 1'b0, 1'b1, 1'b1, 7'b0101111, 8'd5},  // R5 ROM last word, upper lane
      '{24'h020000, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1010111, 8'd5},  // R5 ROM lower lane write
      '{24'h040000, 1'b0, 1'b0, 1'b0, 1'b1, 7'b0111111, 8'd3},  // R3 first word past ROM
      '{24'h0FFFFE, 1'b0, 1'b0, 1'b0, 1'b1, 7'b0111111, 8'd4},  // R4 word below RAM
      '{24'h100000, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1011101, 8'd5},  // R5 RAM lower lane write
      '{24'h100000, 1'b0, 1'b0, 1'b1, 1'b0, 7'b1011011, 8'd5},  // R5 RAM upper lane write
      '{24'h13FFFE, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1011001, 8'd4},  // R4 RAM last word
      '{24'h140000, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1011111, 8'd4},  // R4 first word past RAM
      '{24'h200000, 1'b0, 1'b1, 1'b1, 1'b1, 7'b0111110, 8'd6},  // R6 I/O without lanes
      '{24'h20FFFE, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1011110, 8'd6},  // R6 I/O last word
      '{24'h210000, 1'b0, 1'b0, 1'b0, 1'b1, 7'b0111111, 8'd6},  // R6 past I/O
      '{24'hFFFFFE, 1'b0, 1'b0, 1'b0, 1'b1, 7'b0111111, 8'd6},  // R6 top of space
      '{24'h100000, 1'b1, 1'b0, 1'b0, 1'b0, 7'b1111111, 8'd1},  // R1 idle strobe on RAM
      '{24'h000000, 1'b0, 1'b1, 1'b1, 1'b1, 7'b0111111, 8'd5}   // R5 no lane strobed
   };

   task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] bus_outs();
      return {rd_n, wr_n, rom_hi_cs_n, rom_lo_cs_n, ram_hi_cs_n, ram_lo_cs_n, io_cs_n};
   endfunction

   function automatic logic [2:0] exp_ipl(input logic [7:1] req_n);
      logic [2:0] lvl = '0;
      for (int b = 1; b <= 7; b++) if (!req_n[b]) lvl = 3'(b);
      return ~lvl;
   endfunction

   task automatic drive_irq(input logic [7:1] v);
      @(posedge clk);
      irq_n = v;
      @(negedge clk);
   endtask

   initial begin
      addr = '0; as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rw = 1'b1; irq_n = '1;
      @(negedge clk);

      // Rest state: bus idle, no requests (R1, R9)
      check("R1 rest bus outputs", {3'b0, bus_outs()}, {3'b0, 7'b1111111});
      check("R9 rest level", {7'b0, ipl_n}, {7'b0, 3'b111});

      // Vector table walk (R1..R6)
      for (int i = 0; i < NV; i++) begin
         @(posedge clk);
         addr  = VECS[i].a[23:1];
         as_n  = VECS[i].as_n;
         uds_n = VECS[i].uds_n;
         lds_n = VECS[i].lds_n;
         rw    = VECS[i].rw;
         @(negedge clk);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), {3'b0, bus_outs()}, {3'b0, VECS[i].exp});
      end

      // Directed interrupt cases
      as_n = 1'b1;
      drive_irq(7'b1111111);
      check("R9 no request", {7'b0, ipl_n}, {7'b0, 3'b111});
      drive_irq(7'b0111111);
      check("R7 request 7", {7'b0, ipl_n}, {7'b0, 3'b000});
      drive_irq(7'b1011111);
      check("R7 request 6 alone", {7'b0, ipl_n}, {7'b0, 3'b001});
      drive_irq(7'b1001111);
      check("R8 request 6 with 5", {7'b0, ipl_n}, {7'b0, 3'b001});
      drive_irq(7'b1000000);
      check("R8 request 6 with all lower", {7'b0, ipl_n}, {7'b0, 3'b001});
      drive_irq(7'b1111110);
      check("R7 request 1 alone", {7'b0, ipl_n}, {7'b0, 3'b110});

      // R10: bus activity does not move the level
      @(posedge clk);
      as_n = 1'b0; addr = 23'h080000; uds_n = 1'b0; lds_n = 1'b0; rw = 1'b0;
      @(negedge clk);
      check("R10 level during bus cycle", {7'b0, ipl_n}, {7'b0, 3'b110});
      @(posedge clk);
      as_n = 1'b1;
      @(negedge clk);
      check("R10 level after bus cycle", {7'b0, ipl_n}, {7'b0, 3'b110});

      // Exhaustive request walk (R7, R8, R9)
      for (int p = 0; p < 128; p++) begin
         drive_irq(~7'(p));
         check($sformatf("R7 pattern %0d", p), {7'b0, ipl_n}, {7'b0, exp_ipl(~7'(p))});
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      #(WATCHDOG_NS);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule